// File: doc/BRIEF.md
# PC Card Memory Access Controller

This block sits on the host side of a 16-bit PC Card memory slot. It runs single read or write accesses to either of the card's two memory spaces: common memory and attribute memory. The requester supplies a 26-bit address, a two-bit byte-lane code, a space flag and a direction, all held for one clock with `reqValid` while `reqReady` is high. The controller then drives the card's address, the two active-low card enables, the active-low space select and the active-low read and write strobes. It returns read data and a single-cycle completion pulse.

An access has a fixed order. If the card reports busy, the controller waits first. It then runs a setup phase with address, enables and space select valid and both strobes high. Next comes the strobe phase, which has a programmable minimum width and is stretched by the card's active-low wait input. One hold cycle with the strobe released follows, and then the completion pulse. The setup and strobe lengths come from two configuration inputs, which are captured when a request is accepted.

Top module: `pcmem_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until a request arrives, both card enables, the space select and both strobes are high, `cardDataOe` is low, `rspDone` is low and `reqReady` is high.
- R2: The lane code selects the enables: code 01 drives `cardCe1N` low and `cardCe2N` high (low byte, bits 7:0). Code 10 drives `cardCe1N` high and `cardCe2N` low (high byte, bits 15:8). Code 11 drives both low (full word). The enables keep that pattern for the whole access.
- R3: A request with lane code 00 asserts no enable and no strobe, and still produces the completion pulse.
- R4: With `reqAttr` = 1, `cardRegN` is low during the access (attribute space). With `reqAttr` = 0, it stays high (common space). `cardAddr` carries the request address while the strobe is low.
- R5: Enables, space select and address are valid for max(`cfgSetup`,1) cycles before the strobe falls, and for exactly one cycle after it rises.
- R6: A read pulses only `cardOeN` and a write pulses only `cardWeN`; the two are never low together. The strobe lasts max(`cfgStrobe`,1) cycles plus one cycle for every cycle in which `cardWaitN` is low during the strobe.
- R7: On a write, `cardDataOe` rises one cycle before `cardWeN` falls and falls one cycle after it rises. While the strobe is low, `cardDataOut` equals the write data with the byte of any unselected lane forced to zero.
- R8: On a read, `rspRdata` holds the card data present during the last strobe cycle, with the byte of any unselected lane zero.
- R9: While `cardReady` is low before an access starts, no enable is asserted. The access begins once `cardReady` is high.
- R10: `rspDone` is high for exactly one cycle, in the cycle after the hold cycle, and `reqReady` is high again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSetup | input | 4 | Setup cycles before the strobe (0 is treated as 1) |
| cfgStrobe | input | 4 | Minimum strobe cycles (0 is treated as 1) |
| reqValid | input | 1 | Request present; taken while reqReady is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAttr | input | 1 | 1 = attribute space, 0 = common space |
| reqLane | input | 2 | Byte lane code: 00 none, 01 low, 10 high, 11 word |
| reqAddr | input | 26 | Card byte address |
| reqWdata | input | 16 | Write data |
| reqReady | output | 1 | Controller idle, able to take a request |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | 16 | Read data, unselected byte zero |
| cardAddr | output | 26 | Card address lines |
| cardCe1N | output | 1 | Low-byte card enable, active low |
| cardCe2N | output | 1 | High-byte card enable, active low |
| cardRegN | output | 1 | Space select, low = attribute space |
| cardOeN | output | 1 | Read strobe, active low |
| cardWeN | output | 1 | Write strobe, active low |
| cardDataOut | output | 16 | Data driven to the card |
| cardDataOe | output | 1 | Enable for the data drivers |
| cardDataIn | input | 16 | Data from the card |
| cardWaitN | input | 1 | Card wait request, active low |
| cardReady | input | 1 | Card ready, low = busy |

## Verification
The bench builds the block with its default 26-bit address, 16-bit data and 4-bit timing counters. With those values, both timing extremes can be reached in a few dozen cycles: the zero settings that fold to one, and the full value of fifteen. The top address bit can also be exercised. A card model changes its read data on every strobe cycle, so the bench can tell which cycle was sampled. The model also raises wait and busy for chosen spans, so the stretched strobe and the held-off start can be counted against the programmed values.

// File: rtl/pcmem_pkg.sv
package pcmem_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_BUSY,
    S_SETUP,
    S_STROBE,
    S_HOLD,
    S_DONE
  } pcmem_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;    // capture the request fields
    logic laneOn;     // enables and space select active
    logic oeOn;       // read strobe active
    logic weOn;       // write strobe active
    logic driveData;  // drive write data toward the card
    logic capture;    // sample card data into the read register
  } pcmem_ctl_t;

endpackage

// File: rtl/pcmem_ctrl_fsm.sv
module pcmem_ctrl_fsm
  import pcmem_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgStrobe,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqLaneNone,
  input  logic             cardReady,
  input  logic             cardWaitN,
  output pcmem_ctl_t       ctl,
  output logic             reqReady,
  output logic             rspDone
);

  pcmem_state_e state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] setupLim;
  logic [CNT_W-1:0] strobeLim;
  logic isWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cnt       <= '0;
      setupLim  <= '0;
      strobeLim <= '0;
      isWrite   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          isWrite   <= reqWrite;
          setupLim  <= (cfgSetup == '0) ? '0 : cfgSetup - 1'b1;
          strobeLim <= (cfgStrobe == '0) ? '0 : cfgStrobe - 1'b1;
          cnt       <= '0;
          state     <= reqLaneNone ? S_DONE : S_BUSY;
        end
        S_BUSY: if (cardReady) begin
          cnt   <= '0;
          state <= S_SETUP;
        end
        S_SETUP: begin
          if (cnt == setupLim) begin
            cnt   <= '0;
            state <= S_STROBE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STROBE: if (cardWaitN) begin
          // wait cycles do not advance the width counter
          if (cnt == strobeLim) state <= S_HOLD;
          else                  cnt   <= cnt + 1'b1;
        end
        S_HOLD:  state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.loadReq   = (state == S_IDLE) && reqValid;
    ctl.laneOn    = (state == S_SETUP) || (state == S_STROBE) || (state == S_HOLD);
    ctl.oeOn      = (state == S_STROBE) && !isWrite;
    ctl.weOn      = (state == S_STROBE) && isWrite;
    ctl.driveData = isWrite && (((state == S_SETUP) && (cnt == setupLim)) ||
                                (state == S_STROBE) || (state == S_HOLD));
    ctl.capture   = (state == S_STROBE) && !isWrite && cardWaitN && (cnt == strobeLim);
  end

  assign reqReady = (state == S_IDLE);
  assign rspDone  = (state == S_DONE);

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  // R9: a busy card keeps the access from starting
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BUSY && !cardReady) |=> (state == S_BUSY));

  // R6: wait keeps the strobe phase alive
  p_wait_stretch_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_STROBE && !cardWaitN) |=> (state == S_STROBE));

endmodule

// File: rtl/pcmem_datapath.sv
module pcmem_datapath
  import pcmem_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pcmem_ctl_t           ctl,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 reqAttr,
  input  logic [DATA_W/8-1:0]  reqLane,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    cardDataIn,
  output logic [ADDR_W-1:0]    cardAddr,
  output logic                 cardCe1N,
  output logic                 cardCe2N,
  output logic                 cardRegN,
  output logic                 cardOeN,
  output logic                 cardWeN,
  output logic [DATA_W-1:0]    cardDataOut,
  output logic                 cardDataOe,
  output logic [DATA_W-1:0]    rspRdata
);

  localparam int BYTE_W = 8;
  localparam int LANES  = DATA_W / BYTE_W;

  logic [ADDR_W-1:0] addrQ;
  logic              attrQ;
  logic [LANES-1:0]  laneQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      attrQ  <= 1'b0;
      laneQ  <= '0;
      wdataQ <= '0;
    end else if (ctl.loadReq) begin
      addrQ  <= reqAddr;
      attrQ  <= reqAttr;
      laneQ  <= reqLane;
      wdataQ <= reqWdata;
    end
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    logic [BYTE_W-1:0] rdByte;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            rdByte <= '0;
      else if (ctl.capture) rdByte <= laneQ[ln] ? cardDataIn[ln*BYTE_W +: BYTE_W] : '0;
    end
    assign rspRdata[ln*BYTE_W +: BYTE_W]    = rdByte;
    assign cardDataOut[ln*BYTE_W +: BYTE_W] = laneQ[ln] ? wdataQ[ln*BYTE_W +: BYTE_W] : '0;
  end

  assign cardAddr   = addrQ;
  assign cardCe1N   = !(ctl.laneOn && laneQ[0]);
  assign cardCe2N   = !(ctl.laneOn && laneQ[LANES-1]);
  assign cardRegN   = !(ctl.laneOn && attrQ);
  assign cardOeN    = !ctl.oeOn;
  assign cardWeN    = !ctl.weOn;
  assign cardDataOe = ctl.driveData;

  // R6: read and write strobes are exclusive
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(!cardOeN && !cardWeN));

  // R5: a strobe is only ever inside an enabled access
  p_strobe_needs_en_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cardOeN || !cardWeN) |-> (!cardCe1N || !cardCe2N));

  // R7: write data is driven whenever the write strobe is low
  p_data_with_we_r7: assert property (@(posedge clk) disable iff (!rstN)
    !cardWeN |-> cardDataOe);

endmodule

// File: rtl/pcmem_ctrl.sv
module pcmem_ctrl
  import pcmem_pkg::*;
#(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CNT_W-1:0]    cfgSetup,
  input  logic [CNT_W-1:0]    cfgStrobe,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqAttr,
  input  logic [DATA_W/8-1:0] reqLane,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                reqReady,
  output logic                rspDone,
  output logic [DATA_W-1:0]   rspRdata,
  output logic [ADDR_W-1:0]   cardAddr,
  output logic                cardCe1N,
  output logic                cardCe2N,
  output logic                cardRegN,
  output logic                cardOeN,
  output logic                cardWeN,
  output logic [DATA_W-1:0]   cardDataOut,
  output logic                cardDataOe,
  input  logic [DATA_W-1:0]   cardDataIn,
  input  logic                cardWaitN,
  input  logic                cardReady
);

  pcmem_ctl_t ctl;
  logic laneNone;

  assign laneNone = (reqLane == '0);

  pcmem_ctrl_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .cfgSetup   (cfgSetup),
    .cfgStrobe  (cfgStrobe),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqLaneNone(laneNone),
    .cardReady  (cardReady),
    .cardWaitN  (cardWaitN),
    .ctl        (ctl),
    .reqReady   (reqReady),
    .rspDone    (rspDone)
  );

  pcmem_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqAddr    (reqAddr),
    .reqAttr    (reqAttr),
    .reqLane    (reqLane),
    .reqWdata   (reqWdata),
    .cardDataIn (cardDataIn),
    .cardAddr   (cardAddr),
    .cardCe1N   (cardCe1N),
    .cardCe2N   (cardCe2N),
    .cardRegN   (cardRegN),
    .cardOeN    (cardOeN),
    .cardWeN    (cardWeN),
    .cardDataOut(cardDataOut),
    .cardDataOe (cardDataOe),
    .rspRdata   (rspRdata)
  );

endmodule

// File: tb/pcmem_ctrl_test.sv
module pcmem_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  cfgSetup = '0;
  logic [3:0]  cfgStrobe = '0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqAttr = 1'b0;
  logic [1:0]  reqLane = '0;
  logic [25:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        reqReady;
  logic        rspDone;
  logic [15:0] rspRdata;
  logic [25:0] cardAddr;
  logic        cardCe1N, cardCe2N, cardRegN, cardOeN, cardWeN;
  logic [15:0] cardDataOut;
  logic        cardDataOe;
  logic [15:0] cardDataIn = '0;
  logic        cardWaitN = 1'b1;
  logic        cardReady = 1'b1;

  always #5 clk = !clk;

  pcmem_ctrl uut (
    .clk(clk), .rstN(rstN), .cfgSetup(cfgSetup), .cfgStrobe(cfgStrobe),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAttr(reqAttr), .reqLane(reqLane),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady), .rspDone(rspDone),
    .rspRdata(rspRdata), .cardAddr(cardAddr), .cardCe1N(cardCe1N), .cardCe2N(cardCe2N),
    .cardRegN(cardRegN), .cardOeN(cardOeN), .cardWeN(cardWeN), .cardDataOut(cardDataOut),
    .cardDataOe(cardDataOe), .cardDataIn(cardDataIn), .cardWaitN(cardWaitN),
    .cardReady(cardReady)
  );

  int tests = 0;
  int failed = 0;
  bit finished = 0;

  // monitor results per access
  int setupCnt, holdCnt, strobeCnt, oeCnt, weCnt, driveCnt, badEn, badBusy, badData;
  int waitLen;
  bit seenStrobe;
  logic [1:0]  expEn;
  logic [15:0] expOut;
  logic [15:0] readBase;
  logic [25:0] addrAtStrobe;
  logic        regAtStrobe;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bus monitor and card model, both at the falling edge
  always @(negedge clk) begin
    if (!cardOeN || !cardWeN) begin
      int idx;
      strobeCnt++;
      idx = strobeCnt - 1;
      if (!seenStrobe) begin
        seenStrobe   = 1;
        addrAtStrobe = cardAddr;
        regAtStrobe  = cardRegN;
      end
      if (!cardOeN) oeCnt++;
      if (!cardWeN) begin
        weCnt++;
        if (cardDataOut != expOut) badData++;
      end
      cardWaitN  <= !(idx >= 1 && idx <= waitLen);
      cardDataIn <= readBase + 16'(idx);
    end else begin
      cardWaitN <= 1'b1;
      if (!cardCe1N || !cardCe2N) begin
        if (!seenStrobe) setupCnt++;
        else             holdCnt++;
      end
    end
    if ((!cardCe1N || !cardCe2N) && ({cardCe2N, cardCe1N} != expEn)) badEn++;
    if ((!cardCe1N || !cardCe2N) && !cardReady) badBusy++;
    if (cardDataOe) driveCnt++;
  end

  task automatic doXfer(input bit wr, input bit attr, input logic [1:0] lane,
                        input logic [25:0] addr, input logic [15:0] wd,
                        input int su, input int st, input int wl, input int busy);
    int suEff, stEff, expWidth;
    bit gotDone;
    logic [15:0] mask;
    suEff = (su == 0) ? 1 : su;
    stEff = (st == 0) ? 1 : st;
    expWidth = stEff + ((stEff >= 2) ? wl : 0);
    mask = {{8{lane[1]}}, {8{lane[0]}}};
    @(posedge clk); #2;
    setupCnt = 0; holdCnt = 0; strobeCnt = 0; oeCnt = 0; weCnt = 0; driveCnt = 0;
    badEn = 0; badBusy = 0; badData = 0; seenStrobe = 0;
    waitLen = wl; expEn = ~lane; expOut = wd & mask;
    readBase = 16'hA5C0 ^ addr[15:0];
    cfgSetup = 4'(su); cfgStrobe = 4'(st);
    reqValid = 1; reqWrite = wr; reqAttr = attr; reqLane = lane; reqAddr = addr; reqWdata = wd;
    cardReady = (busy == 0);
    @(posedge clk); #2;
    reqValid = 0;
    if (busy > 0) begin
      repeat (busy) @(posedge clk);
      #2 cardReady = 1;
    end
    gotDone = 0;
    for (int i = 0; i < 300 && !gotDone; i++) begin
      @(negedge clk);
      if (rspDone) gotDone = 1;
    end
    #1;
    check(gotDone, "R10 done pulse seen", gotDone, 1);
    if (lane == 2'b00) begin
      check(setupCnt + strobeCnt + holdCnt == 0, "R3 no enable for lane 00",
            setupCnt + strobeCnt + holdCnt, 0);
      check(oeCnt + weCnt == 0, "R3 no strobe for lane 00", oeCnt + weCnt, 0);
    end else begin
      check(badEn == 0, "R2 enable pattern", badEn, 0);
      check(regAtStrobe == !attr, "R4 space select", regAtStrobe, !attr);
      check(addrAtStrobe == addr, "R4 address", addrAtStrobe, addr);
      check(setupCnt == suEff, "R5 setup cycles", setupCnt, suEff);
      check(holdCnt == 1, "R5 hold cycle", holdCnt, 1);
      check(strobeCnt == expWidth, "R6 strobe width", strobeCnt, expWidth);
      check(wr ? (oeCnt == 0 && weCnt == expWidth) : (weCnt == 0 && oeCnt == expWidth),
            "R6 strobe kind", wr ? oeCnt : weCnt, 0);
      check(badBusy == 0, "R9 no enable while busy", badBusy, 0);
      if (wr) begin
        check(driveCnt == expWidth + 2, "R7 data drive window", driveCnt, expWidth + 2);
        check(badData == 0, "R7 write data and lane zeroing", badData, 0);
      end else begin
        check(driveCnt == 0, "R7 no drive on read", driveCnt, 0);
        check(rspRdata == ((readBase + 16'(expWidth - 1)) & mask), "R8 read data",
              rspRdata, (readBase + 16'(expWidth - 1)) & mask);
      end
    end
    @(negedge clk); #1;
    check(!rspDone, "R10 single-cycle done", rspDone, 0);
    check(reqReady, "R10 ready after done", reqReady, 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check({cardCe1N, cardCe2N, cardRegN, cardOeN, cardWeN} == 5'h1F, "R1 pins idle in reset",
          {cardCe1N, cardCe2N, cardRegN, cardOeN, cardWeN}, 5'h1F);
    check(!cardDataOe && !rspDone, "R1 no drive and no done", {cardDataOe, rspDone}, 0);
    rstN = 1;
    @(negedge clk);
    @(negedge clk);
    check(reqReady, "R1 ready after reset", reqReady, 1);
    check({cardCe1N, cardCe2N, cardRegN, cardOeN, cardWeN} == 5'h1F, "R1 pins idle after reset",
          {cardCe1N, cardCe2N, cardRegN, cardOeN, cardWeN}, 5'h1F);
  endtask

  task automatic testWordWriteCommon();  // R2 R4 R5 R6 R7
    doXfer(1, 0, 2'b11, 26'h2345678, 16'hBEEF, 2, 3, 0, 0);
  endtask

  task automatic testLowReadAttr();      // R2 R8 low lane
    doXfer(0, 1, 2'b01, 26'h0000102, 16'h0, 1, 1, 0, 0);
  endtask

  task automatic testHighWriteZeroCfg(); // R5 R6 zero folds to one, R7 low byte zeroed
    doXfer(1, 1, 2'b10, 26'h1000001, 16'h3C96, 0, 0, 0, 0);
  endtask

  task automatic testHighReadWait();     // R6 R8 wait stretch on read
    doXfer(0, 0, 2'b10, 26'h0ABCDE0, 16'h0, 3, 2, 4, 0);
  endtask

  task automatic testWriteWait();        // R6 R7 wait stretch on write
    doXfer(1, 0, 2'b11, 26'h0000FF0, 16'h1234, 1, 3, 2, 0);
  endtask

  task automatic testBusyCard();         // R9
    doXfer(0, 1, 2'b11, 26'h0055AA0, 16'h0, 2, 2, 0, 5);
  endtask

  task automatic testNoLane();           // R3
    doXfer(1, 0, 2'b00, 26'h0000010, 16'hFFFF, 2, 2, 0, 0);
  endtask

  task automatic testLongest();          // R5 R6 at counter limit, top address bit
    doXfer(0, 0, 2'b11, 26'h3FFFFFF, 16'h0, 15, 15, 3, 0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    check(0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    testReset();
    testWordWriteCommon();
    testLowReadAttr();
    testHighWriteZeroCfg();
    testHighReadWait();
    testWriteWait();
    testBusyCard();
    testNoLane();
    testLongest();
    report();
  end

endmodule